// File: doc/BRIEF.md
# RTC Status and Write-Enable Register

This block holds the volatile status byte of a serial-bus real-time clock and gates every write the bus makes. It sits behind a bus front end that has already turned the serial traffic into byte-level events. Those events are a write strobe carrying an address space, an address and a data byte, a pulse when a status read begins, and a pulse on the falling edge of the last data bit of that read. The block returns the status byte. For each write it also returns, in the same cycle, whether the data byte is acknowledged, along with one-cycle permit pulses for the memory array and for the clock/control registers.

Two write-enable latches protect the device. The first covers the array. The second, which can only be armed once the first is set, covers the clock/control registers. Both latches are set only by exact byte values written in a fixed order. The block also keeps a power-fail flag, loaded when power comes back after every supply was lost. The first accepted clock-register write clears that flag. A battery-operation bit follows the supply-mode input, and two alarm flags latch match pulses from the timekeeping logic. A status read clears only the alarm flags that were already set when the read began.

Reset stands for power-up. Every status write takes effect at the next clock edge, and there is no busy period after it.

Top module: `rtc_status_reg`

## Requirements
- R1: Reset clears both enable latches, both alarm flags and the pending-clear state. During reset the power-fail flag loads the value of `pwr_lost_i`.
- R2: The status byte reads as bit7 battery mode (the current level of `batt_mode_i`), bit6 alarm 1, bit5 alarm 0, bits 4 and 3 always 0, bit2 register enable, bit1 write enable, bit0 power-fail.
- R3: A write of 02h to the status address (clock/control space, address 3Fh) is always acknowledged. From the next cycle it leaves the write enable set and the register enable clear.
- R4: A write of 06h to the status address sets the register enable only when the write enable is already set. If the write enable is clear, the write is not acknowledged and neither latch changes.
- R5: While the write enable is set, a write of 00h to the status address clears both latches, and any other value except 02h and 06h is acknowledged with no effect. While the write enable is clear, every status write except 02h is not acknowledged and has no effect.
- R6: An array write (`wr_ccr_i`=0) is acknowledged, and pulses `array_wr_en_o`, only while the write enable is set. Otherwise `wr_nack_o` is raised.
- R7: A clock/control write to an address other than the status address is acknowledged, and pulses `ccr_wr_en_o`, only while both latches are set.
- R8: The power-fail flag never rises outside reset. An accepted clock/control write to a non-status address clears it from the next cycle.
- R9: A pulse on `alarm_hit_i[n]` sets alarm flag n from the next cycle. The flag stays set until a status read clears it.
- R10: When `rd_start_i` pulses, the block records which alarm flags are set. On `rd_done_i` only those recorded flags clear. A flag raised after the read began, including one raised in the same cycle as `rd_done_i`, stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| pwr_lost_i | input | 1 | All supplies were lost before this power-up |
| batt_mode_i | input | 1 | 1 while running from the backup supply |
| alarm_hit_i | input | 2 | One-cycle alarm match pulses, bit n for alarm n |
| wr_stb_i | input | 1 | Write data byte strobe |
| wr_ccr_i | input | 1 | 1 = clock/control space, 0 = memory array |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | 8 | Write data byte |
| rd_start_i | input | 1 | Status read begins |
| rd_done_i | input | 1 | Falling edge of the last data bit of a status read |
| sr_rdata_o | output | 8 | Status byte |
| wr_ack_o | output | 1 | Current write byte is acknowledged |
| wr_nack_o | output | 1 | Current write byte gets no acknowledge |
| array_wr_en_o | output | 1 | Permit pulse for the memory array |
| ccr_wr_en_o | output | 1 | Permit pulse for the clock/control registers |

## Verification
The assertions assume that every strobe and pulse lasts one cycle, that `rd_done_i` only follows an earlier `rd_start_i` and never coincides with it, and that the ack outputs are read only in a cycle where `wr_stb_i` is high. The stimulus is driven one event at a time from tasks that lower every pulse after a single clock, and it always issues a read start before the matching read end. Alarm pulses are placed before a read, between its start and end, and on the same cycle as its end, so that both kept and cleared flags are covered.

// File: rtl/sr_pkg.sv
package sr_pkg;

    localparam int SR_W        = 8;
    localparam int ALARM_N     = 2;

    localparam logic [7:0] CODE_CLEAR   = 8'h00;
    localparam logic [7:0] CODE_ARM     = 8'h02;
    localparam logic [7:0] CODE_ARM_REG = 8'h06;

    localparam int BIT_BAT  = 7;
    localparam int BIT_AL1  = 6;
    localparam int BIT_AL0  = 5;
    localparam int BIT_RWEN = 2;
    localparam int BIT_WEN  = 1;
    localparam int BIT_PFAIL = 0;

    typedef struct packed {
        logic rwen;
        logic wen;
    } wen_t;

    typedef enum logic [1:0] {
        CMD_CLEAR,
        CMD_ARM,
        CMD_ARM_REG,
        CMD_OTHER
    } sr_cmd_t;

    function automatic sr_cmd_t decode_cmd(input logic [7:0] data);
        sr_cmd_t c;
        if (data == CODE_CLEAR)        c = CMD_CLEAR;
        else if (data == CODE_ARM)     c = CMD_ARM;
        else if (data == CODE_ARM_REG) c = CMD_ARM_REG;
        else                           c = CMD_OTHER;
        return c;
    endfunction

    function automatic logic [SR_W-1:0] pack_status(
        input logic               bat,
        input logic [ALARM_N-1:0] al,
        input wen_t               w,
        input logic               pfail
    );
        logic [SR_W-1:0] s;
        s            = '0;
        s[BIT_BAT]   = bat;
        s[BIT_AL1]   = al[1];
        s[BIT_AL0]   = al[0];
        s[BIT_RWEN]  = w.rwen;
        s[BIT_WEN]   = w.wen;
        s[BIT_PFAIL] = pfail;
        return s;
    endfunction

endpackage

// File: rtl/sr_write_gate.sv
module sr_write_gate
    import sr_pkg::*;
#(
    parameter int               ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] SR_ADDR = ADDR_W'('h3F)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb_i,
    input  logic              wr_ccr_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [7:0]        wr_data_i,
    output wen_t              wen_o,
    output logic              wr_ok_o,
    output logic              array_wr_en_o,
    output logic              ccr_wr_en_o
);

    wen_t    wen_q;
    wen_t    wen_d;
    logic    hit_sr;
    sr_cmd_t cmd;

    assign hit_sr = wr_ccr_i && (wr_addr_i == SR_ADDR);
    assign cmd    = decode_cmd(wr_data_i);

    always_comb begin
        wen_d         = wen_q;
        wr_ok_o       = 1'b0;
        array_wr_en_o = 1'b0;
        ccr_wr_en_o   = 1'b0;
        if (wr_stb_i) begin
            if (hit_sr) begin
                wr_ok_o = (cmd == CMD_ARM) || wen_q.wen;
                if (wr_ok_o) begin
                    case (cmd)
                        CMD_CLEAR:   wen_d = '0;
                        CMD_ARM:     begin wen_d.wen = 1'b1; wen_d.rwen = 1'b0; end
                        CMD_ARM_REG: wen_d.rwen = 1'b1;
                        default:     wen_d = wen_q;
                    endcase
                end
            end else if (wr_ccr_i) begin
                wr_ok_o     = wen_q.wen && wen_q.rwen;
                ccr_wr_en_o = wr_ok_o;
            end else begin
                wr_ok_o       = wen_q.wen;
                array_wr_en_o = wr_ok_o;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) wen_q <= '0;
        else     wen_q <= wen_d;
    end

    assign wen_o = wen_q;

endmodule

// File: rtl/sr_power_flag.sv
module sr_power_flag (
    input  logic clk,
    input  logic rst,
    input  logic pwr_lost_i,
    input  logic clear_i,
    output logic pfail_o
);

    logic pfail_q;

    always_ff @(posedge clk) begin
        if (rst)          pfail_q <= pwr_lost_i;
        else if (clear_i) pfail_q <= 1'b0;
    end

    assign pfail_o = pfail_q;

endmodule

// File: rtl/sr_alarm_bank.sv
module sr_alarm_bank #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] hit_i,
    input  logic         rd_start_i,
    input  logic         rd_done_i,
    output logic [N-1:0] flag_o
);

    for (genvar g = 0; g < N; g++) begin : g_flag
        logic flag_q;
        logic mask_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                flag_q <= 1'b0;
                mask_q <= 1'b0;
            end else begin
                if (rd_start_i)     mask_q <= flag_q;
                else if (rd_done_i) mask_q <= 1'b0;
                flag_q <= (flag_q & ~(rd_done_i & mask_q)) | hit_i[g];
            end
        end

        assign flag_o[g] = flag_q;
    end

endmodule

// File: rtl/rtc_status_reg.sv
module rtc_status_reg
    import sr_pkg::*;
#(
    parameter int                ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] SR_ADDR = ADDR_W'('h3F)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_lost_i,
    input  logic              batt_mode_i,
    input  logic [1:0]        alarm_hit_i,
    input  logic              wr_stb_i,
    input  logic              wr_ccr_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [7:0]        wr_data_i,
    input  logic              rd_start_i,
    input  logic              rd_done_i,
    output logic [7:0]        sr_rdata_o,
    output logic              wr_ack_o,
    output logic              wr_nack_o,
    output logic              array_wr_en_o,
    output logic              ccr_wr_en_o
);

    wen_t              wen;
    logic              wr_ok;
    logic              ccr_en;
    logic              pfail;
    logic [ALARM_N-1:0] alarms;

    sr_write_gate #(
        .ADDR_W  (ADDR_W),
        .SR_ADDR (SR_ADDR)
    ) u_gate (
        .clk           (clk),
        .rst           (rst),
        .wr_stb_i      (wr_stb_i),
        .wr_ccr_i      (wr_ccr_i),
        .wr_addr_i     (wr_addr_i),
        .wr_data_i     (wr_data_i),
        .wen_o         (wen),
        .wr_ok_o       (wr_ok),
        .array_wr_en_o (array_wr_en_o),
        .ccr_wr_en_o   (ccr_en)
    );

    sr_power_flag u_pfail (
        .clk        (clk),
        .rst        (rst),
        .pwr_lost_i (pwr_lost_i),
        .clear_i    (ccr_en),
        .pfail_o    (pfail)
    );

    sr_alarm_bank #(
        .N (ALARM_N)
    ) u_alarms (
        .clk        (clk),
        .rst        (rst),
        .hit_i      (alarm_hit_i),
        .rd_start_i (rd_start_i),
        .rd_done_i  (rd_done_i),
        .flag_o     (alarms)
    );

    assign sr_rdata_o  = pack_status(batt_mode_i, alarms, wen, pfail);
    assign wr_ack_o    = wr_ok;
    assign wr_nack_o   = wr_stb_i && !wr_ok;
    assign ccr_wr_en_o = ccr_en;

endmodule

// File: rtl/rtc_status_reg_chk.sv
module rtc_status_reg_chk #(
    parameter int                ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] SR_ADDR = ADDR_W'('h3F)
) (
    input logic              clk,
    input logic              rst,
    input logic              batt_mode_i,
    input logic [1:0]        alarm_hit_i,
    input logic              wr_stb_i,
    input logic              wr_ccr_i,
    input logic [ADDR_W-1:0] wr_addr_i,
    input logic [7:0]        wr_data_i,
    input logic [7:0]        sr_rdata_o,
    input logic              wr_ack_o,
    input logic              wr_nack_o,
    input logic              ccr_wr_en_o
);

    logic past_ok;

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    // R2
    unused_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
        sr_rdata_o[4:3] == 2'b00);

    // R2
    bat_follows_level_chk: assert property (@(posedge clk) disable iff (rst)
        sr_rdata_o[7] == batt_mode_i);

    // R3
    arm_sets_wen_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_stb_i && wr_ccr_i && wr_addr_i == SR_ADDR && wr_data_i == 8'h02)
        |=> (sr_rdata_o[1] && !sr_rdata_o[2]));

    // R4
    rwen_needs_wen_chk: assert property (@(posedge clk) disable iff (rst)
        sr_rdata_o[2] |-> sr_rdata_o[1]);

    // R5
    ack_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb_i |-> $onehot0({wr_ack_o, wr_nack_o}) && (wr_ack_o || wr_nack_o));

    // R6
    array_locked_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_stb_i && !wr_ccr_i && !sr_rdata_o[1]) |-> wr_nack_o);

    // R7
    ccr_needs_both_chk: assert property (@(posedge clk) disable iff (rst)
        ccr_wr_en_o |-> (sr_rdata_o[1] && sr_rdata_o[2]));

    // R8
    pfail_no_rise_chk: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> !$rose(sr_rdata_o[0]));

    // R9
    alarm0_latch_chk: assert property (@(posedge clk) disable iff (rst)
        alarm_hit_i[0] |=> sr_rdata_o[5]);

    // R9
    alarm1_latch_chk: assert property (@(posedge clk) disable iff (rst)
        alarm_hit_i[1] |=> sr_rdata_o[6]);

endmodule

bind rtc_status_reg rtc_status_reg_chk #(
    .ADDR_W  (ADDR_W),
    .SR_ADDR (SR_ADDR)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .batt_mode_i (batt_mode_i),
    .alarm_hit_i (alarm_hit_i),
    .wr_stb_i    (wr_stb_i),
    .wr_ccr_i    (wr_ccr_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .sr_rdata_o  (sr_rdata_o),
    .wr_ack_o    (wr_ack_o),
    .wr_nack_o   (wr_nack_o),
    .ccr_wr_en_o (ccr_wr_en_o)
);

// File: tb/rtc_status_reg_tb_top.sv
`timescale 1ns/1ps
module rtc_status_reg_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       pwr_lost_i;
    logic       batt_mode_i;
    logic [1:0] alarm_hit_i;
    logic       wr_stb_i;
    logic       wr_ccr_i;
    logic [7:0] wr_addr_i;
    logic [7:0] wr_data_i;
    logic       rd_start_i;
    logic       rd_done_i;
    logic [7:0] sr_rdata_o;
    logic       wr_ack_o;
    logic       wr_nack_o;
    logic       array_wr_en_o;
    logic       ccr_wr_en_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // behavioural reference state
    bit m_wen, m_rwen, m_pfail;
    bit m_al[2];
    bit m_pend[2];

    always #2.5 clk = ~clk;

    rtc_status_reg dut_i (
        .clk           (clk),
        .rst           (rst),
        .pwr_lost_i    (pwr_lost_i),
        .batt_mode_i   (batt_mode_i),
        .alarm_hit_i   (alarm_hit_i),
        .wr_stb_i      (wr_stb_i),
        .wr_ccr_i      (wr_ccr_i),
        .wr_addr_i     (wr_addr_i),
        .wr_data_i     (wr_data_i),
        .rd_start_i    (rd_start_i),
        .rd_done_i     (rd_done_i),
        .sr_rdata_o    (sr_rdata_o),
        .wr_ack_o      (wr_ack_o),
        .wr_nack_o     (wr_nack_o),
        .array_wr_en_o (array_wr_en_o),
        .ccr_wr_en_o   (ccr_wr_en_o)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp,
                       input string req, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    function automatic bit exp_ok();
        if (wr_ccr_i && wr_addr_i == 8'h3F) return (wr_data_i == 8'h02) || m_wen;
        if (wr_ccr_i) return m_wen && m_rwen;
        return m_wen;
    endfunction

    function automatic logic [7:0] exp_status();
        return {batt_mode_i, m_al[1], m_al[0], 2'b00, m_rwen, m_wen, m_pfail};
    endfunction

    task automatic model_edge();
        bit ok;
        if (rst) begin
            m_wen = 0; m_rwen = 0; m_pfail = pwr_lost_i;
            for (int i = 0; i < 2; i++) begin m_al[i] = 0; m_pend[i] = 0; end
            return;
        end
        if (wr_stb_i) begin
            ok = exp_ok();
            if (ok && wr_ccr_i && wr_addr_i == 8'h3F) begin
                if (wr_data_i == 8'h00)      begin m_wen = 0; m_rwen = 0; end
                else if (wr_data_i == 8'h02) begin m_wen = 1; m_rwen = 0; end
                else if (wr_data_i == 8'h06) m_rwen = 1;
            end else if (ok && wr_ccr_i) begin
                m_pfail = 0;
            end
        end
        for (int i = 0; i < 2; i++) begin
            bit keep;
            keep = m_al[i] && !(rd_done_i && m_pend[i]);
            if (rd_start_i)     m_pend[i] = m_al[i];
            else if (rd_done_i) m_pend[i] = 0;
            m_al[i] = keep || alarm_hit_i[i];
        end
    endtask

    // one clock: check combinational write response, advance, check status
    task automatic step(input string req);
        #1;
        if (wr_stb_i && !rst) begin
            bit ok;
            ok = exp_ok();
            chk({7'b0, wr_ack_o},  {7'b0, ok},  req, "ack");
            chk({7'b0, wr_nack_o}, {7'b0, !ok}, req, "nack");
            chk({7'b0, array_wr_en_o}, {7'b0, ok && !wr_ccr_i}, req, "array_en");
            chk({7'b0, ccr_wr_en_o},
                {7'b0, ok && wr_ccr_i && wr_addr_i != 8'h3F}, req, "ccr_en");
        end
        @(posedge clk);
        model_edge();
        @(negedge clk);
        wr_stb_i = 0; alarm_hit_i = 0; rd_start_i = 0; rd_done_i = 0;
        chk(sr_rdata_o, exp_status(), req, "status");
    endtask

    task automatic wr(input bit ccr, input logic [7:0] a, input logic [7:0] d,
                      input string req);
        wr_stb_i = 1; wr_ccr_i = ccr; wr_addr_i = a; wr_data_i = d;
        step(req);
    endtask

    task automatic do_reset(input bit lost);
        rst = 1; pwr_lost_i = lost;
        step("R1");
        step("R1");
        rst = 0;
        step("R1");
    endtask

    initial begin
        #100000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1; pwr_lost_i = 1; batt_mode_i = 0; alarm_hit_i = 0;
        wr_stb_i = 0; wr_ccr_i = 0; wr_addr_i = 0; wr_data_i = 0;
        rd_start_i = 0; rd_done_i = 0;
        @(negedge clk);
        do_reset(1);
        chk(sr_rdata_o, 8'h01, "R1", "reset status with power lost");

        // locked device
        wr(0, 8'h10, 8'hAA, "R6");
        wr(1, 8'h30, 8'h12, "R7");
        wr(1, 8'h3F, 8'h06, "R4");
        wr(1, 8'h3F, 8'h00, "R5");
        wr(1, 8'h3F, 8'hFF, "R5");
        chk(sr_rdata_o, 8'h01, "R5", "latches untouched while locked");

        // arm write enable
        wr(1, 8'h3F, 8'h02, "R3");
        chk(sr_rdata_o, 8'h03, "R3", "wen set");
        wr(0, 8'h22, 8'h5A, "R6");
        wr(1, 8'h31, 8'h01, "R7");
        chk({7'b0, sr_rdata_o[0]}, 8'h01, "R8", "pfail kept after rejected write");

        // arm register enable, then clock write clears power-fail
        wr(1, 8'h3F, 8'h06, "R4");
        chk(sr_rdata_o, 8'h07, "R4", "rwen set");
        wr(1, 8'h30, 8'h45, "R8");
        chk(sr_rdata_o, 8'h06, "R8", "pfail cleared");
        wr(1, 8'h32, 8'h09, "R7");

        // ignored patterns and disarming
        wr(1, 8'h3F, 8'h55, "R5");
        chk(sr_rdata_o, 8'h06, "R5", "other pattern ignored");
        wr(1, 8'h3F, 8'h02, "R3");
        chk(sr_rdata_o, 8'h02, "R3", "rewrite of 02h drops rwen");
        wr(1, 8'h3F, 8'h06, "R4");
        wr(1, 8'h3F, 8'h00, "R5");
        chk(sr_rdata_o, 8'h00, "R5", "both cleared");
        wr(0, 8'h01, 8'h00, "R6");

        // battery bit
        batt_mode_i = 1;
        step("R2");
        chk(sr_rdata_o, 8'h80, "R2", "bat bit follows level");
        batt_mode_i = 0;
        step("R2");

        // alarms: flag set before read is cleared, one set during read kept
        alarm_hit_i = 2'b01; step("R9");
        chk(sr_rdata_o, 8'h20, "R9", "alarm0 latched");
        step("R9");
        rd_start_i = 1; step("R10");
        alarm_hit_i = 2'b10; step("R10");
        step("R10");
        rd_done_i = 1; step("R10");
        chk(sr_rdata_o, 8'h40, "R10", "only snapshotted flag cleared");
        rd_start_i = 1; step("R10");
        rd_done_i = 1; step("R10");
        chk(sr_rdata_o, 8'h00, "R10", "second read clears alarm1");

        // snapshotted flag re-hit on the same cycle as the read end stays set
        alarm_hit_i = 2'b01; step("R9");
        rd_start_i = 1; step("R10");
        rd_done_i = 1; alarm_hit_i = 2'b01; step("R10");
        chk(sr_rdata_o, 8'h20, "R10", "hit on read end kept");
        // read start in same cycle as a hit: new hit not in snapshot
        rd_start_i = 1; alarm_hit_i = 2'b10; step("R10");
        rd_done_i = 1; step("R10");
        chk(sr_rdata_o, 8'h40, "R10", "hit on read start kept");

        // reset without total loss
        do_reset(0);
        chk(sr_rdata_o, 8'h00, "R1", "reset status without power loss");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule